// File: doc/BRIEF.md
# Segmented Page Translator

This block sits after segment:offset address arithmetic. Every request names one of several segment registers and a 16-bit offset. The block first forms a virtual address from the segment and the offset. It then maps that address through a small internal page table of 4 KB pages and returns a physical address or a page fault.

In legacy mode the segment is scaled by 16, so distinct segment:offset pairs that land on the same byte still alias to it. In extended mode the segment is scaled by 256, which gives a 24-bit (16 MB) virtual space. Each segment register keeps a private one-entry cache holding the page table entry it last used. An access that hits that cache is answered on the next clock. An access that misses asserts a busy signal for one cycle while the cache is refilled from the table, and the requester holds the request until busy drops. Table contents are loaded through a plain write port.

Top module: `seg_page_xlate`

## Requirements
- R1: In legacy mode (`mode_ext`=0) the virtual address is (segment*16 + offset) modulo 2^20, so aliasing pairs such as 0x0012:0x0345 and 0x0011:0x0355 give the same result.
- R2: In extended mode (`mode_ext`=1) the virtual address is (segment*256 + offset) modulo 2^24.
- R3: For an access that does not fault, `rsp_paddr` = translation field * 4096 + virtual address bits [11:0]. The page number (virtual address >> 12) indexes the table.
- R4: A table entry is laid out as translation in bits [31:20], length in bits [19:8] and attributes in bits [7:0]. Attribute bit 0 is present. An access to an entry with bit 0 clear faults with cause 1.
- R5: An access whose in-page offset (virtual address bits [11:0]) is greater than the length field faults with cause 2. An offset equal to the length is allowed.
- R6: A write (`req_write`=1) to an entry whose attribute bit 1 (writable) is clear faults with cause 3. A read of the same page succeeds.
- R7: A faulting response has `rsp_fault`=1, a nonzero `rsp_cause` and `rsp_paddr`=0. When several checks fail, the reported cause follows the order not-present, then length, then write.
- R8: On a hit, `req_busy` stays 0 and the response appears on the clock after the request. On a miss, `req_busy` is 1 for exactly one cycle and the response comes one cycle later.
- R9: A hit uses the cached entry without reading the table. A table write to a page that is already cached does not change that segment's results.
- R10: Writing a segment register invalidates that segment's cached entry, so its next access misses and picks up the current table contents.
- R11: A page number at or beyond the table depth faults with cause 1 at once, without asserting busy.
- R12: After reset, `rsp_valid` and `req_busy` are 0 and every segment's cache is empty, so the first access misses.
- R13: The caches are per segment. Refilling one segment's cache leaves the entries of the other segments in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ext | input | 1 | 0: segment scaled by 16; 1: segment scaled by 256 |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register selected for the write |
| seg_wr_data | input | 16 | New segment value |
| tbl_wr_en | input | 1 | Page table write strobe |
| tbl_wr_idx | input | 6 | Page table entry index |
| tbl_wr_data | input | 32 | Page table entry value |
| req_valid | input | 1 | Translation request present |
| req_seg | input | 2 | Segment register used by the request |
| req_off | input | 16 | Offset within the segment |
| req_write | input | 1 | Request is a write |
| req_busy | output | 1 | Cache refill in progress; hold the request |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 24 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 2 | 0 none, 1 not present/unmapped, 2 length, 3 write protect |

## Verification
The checker watches the handshake and the response on every cycle. It confirms that busy never lasts two cycles for a held request, that no response follows a busy cycle or appears without a request, and that faulting and idle responses carry a zero address with a consistent cause. Only the bench's scenarios can show the address arithmetic of both modes, including aliasing and wrap. The same holds for the field layout, the fault order, stale use of a cached entry after a table write, invalidation on a segment write, and independence between segments.

// File: rtl/spx_pkg.sv
// Package: shared widths, the table entry layout and the fault codes.
// Assumes one fixed page size of 4 KB and 12-bit translation frames.
package spx_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int PAGE_W  = 12;
    localparam int XLAT_W  = 12;
    localparam int VA_W    = SEG_W + 8;
    localparam int VPN_W   = VA_W - PAGE_W;
    localparam int PA_W    = XLAT_W + PAGE_W;

    typedef struct packed {
        logic [XLAT_W-1:0] frame;
        logic [PAGE_W-1:0] limit;
        logic [7:0]        attr;
    } pte_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_LIMIT  = 2'd2,
        FLT_WPROT  = 2'd3
    } fault_e;

    localparam int ATTR_PRESENT  = 0;
    localparam int ATTR_WRITABLE = 1;
endpackage

// File: rtl/spx_vaddr_gen.sv
// Virtual address former: scales the segment by 16 (legacy) or 256 (extended)
// and adds the offset. Assumes the offset is no wider than the legacy space.
module spx_vaddr_gen
    import spx_pkg::*;
(
    input  logic             mode_ext,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [VA_W-1:0]  vaddr
);
    localparam int LEG_W = SEG_W + 4;

    logic [LEG_W-1:0] va_leg;
    logic [VA_W-1:0]  va_ext;

    // Both sums are truncated to their own space, so they wrap.
    always_comb begin
        va_leg = {seg, 4'b0000} + LEG_W'(off);
        va_ext = {seg, 8'h00} + VA_W'(off);
        vaddr  = mode_ext ? va_ext : VA_W'(va_leg);
    end
endmodule

// File: rtl/spx_page_table.sv
// Internal page table: one write port for loading, one combinational read
// port for cache refill. Assumes that the depth is a power of two.
module spx_page_table
    import spx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pte_t             wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output pte_t             rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    pte_t mem [DEPTH];

    // Load entries, and clear all of them to not-present on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Refill read.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/spx_seg_cache.sv
// Segment registers, each with a one-entry page cache tagged by page number.
// A segment write clears that segment's cache and takes priority over a
// refill to it in the same cycle.
module spx_seg_cache
    import spx_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [SEL_W-1:0] seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             fill_en,
    input  logic [SEL_W-1:0] fill_sel,
    input  logic [VPN_W-1:0] fill_vpn,
    input  pte_t             fill_pte,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic [SEG_W-1:0] rd_seg,
    output logic             rd_hit,
    output pte_t             rd_pte
);
    logic [SEG_W-1:0] seg_q   [NSEG];
    logic             valid_q [NSEG];
    logic [VPN_W-1:0] tag_q   [NSEG];
    pte_t             pte_q   [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        // Segment value: reset to zero, replaced on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    seg_q[g] <= '0;
            else if (seg_wr_en && seg_wr_sel == SEL_W'(g)) seg_q[g] <= seg_wr_data;
        end

        // Cached entry: invalidated on a segment write, filled on a miss.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                pte_q[g]   <= '0;
            end else if (seg_wr_en && seg_wr_sel == SEL_W'(g)) begin
                valid_q[g] <= 1'b0;
            end else if (fill_en && fill_sel == SEL_W'(g)) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= fill_vpn;
                pte_q[g]   <= fill_pte;
            end
        end
    end

    // Lookup for the requesting segment.
    always_comb begin
        rd_seg = seg_q[rd_sel];
        rd_hit = valid_q[rd_sel] && (tag_q[rd_sel] == rd_vpn);
        rd_pte = pte_q[rd_sel];
    end
endmodule

// File: rtl/spx_perm_check.sv
// Access check on one entry. Order: not present or unmapped, then length,
// then write protection.
module spx_perm_check
    import spx_pkg::*;
(
    input  logic              mapped,
    input  pte_t              pte,
    input  logic [PAGE_W-1:0] page_off,
    input  logic              is_write,
    output fault_e            cause
);
    // Return the first failing check in priority order.
    always_comb begin
        if (!mapped || !pte.attr[ATTR_PRESENT])        cause = FLT_ABSENT;
        else if (page_off > pte.limit)                 cause = FLT_LIMIT;
        else if (is_write && !pte.attr[ATTR_WRITABLE]) cause = FLT_WPROT;
        else                                           cause = FLT_NONE;
    end
endmodule

// File: rtl/seg_page_xlate.sv
// Segmented page translator top. It forms the virtual address, looks the page
// up in the segment's cache, refills the cache from the table on a miss
// (busy for one cycle), and registers the physical address or a fault.
// Assumes that the requester holds its request while req_busy is high.
module seg_page_xlate
    import spx_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int IDX_W = 6,
    parameter int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ext,
    input  logic             seg_wr_en,
    input  logic [SEL_W-1:0] seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic [31:0]      tbl_wr_data,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_write,
    output logic             req_busy,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
);
    logic [SEG_W-1:0] cur_seg;
    logic [VA_W-1:0]  vaddr;
    logic [VPN_W-1:0] vpn;
    logic             mapped;
    logic             hit;
    pte_t             cached_pte;
    pte_t             table_pte;
    fault_e           cause;
    logic             accept;

    spx_vaddr_gen u_va (
        .mode_ext (mode_ext),
        .seg      (cur_seg),
        .off      (req_off),
        .vaddr    (vaddr)
    );

    // Page number and whether the table covers it.
    always_comb begin
        vpn    = vaddr[VA_W-1:PAGE_W];
        mapped = (vpn >> IDX_W) == '0;
    end

    spx_page_table #(.IDX_W(IDX_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (pte_t'(tbl_wr_data)),
        .rd_idx  (vpn[IDX_W-1:0]),
        .rd_data (table_pte)
    );

    spx_seg_cache #(.NSEG(NSEG), .SEL_W(SEL_W)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .fill_en     (req_busy),
        .fill_sel    (req_seg),
        .fill_vpn    (vpn),
        .fill_pte    (table_pte),
        .rd_sel      (req_seg),
        .rd_vpn      (vpn),
        .rd_seg      (cur_seg),
        .rd_hit      (hit),
        .rd_pte      (cached_pte)
    );

    // Busy only when a mapped page misses; unmapped pages answer at once.
    always_comb begin
        req_busy = req_valid && mapped && !hit;
        accept   = req_valid && !req_busy;
    end

    spx_perm_check u_chk (
        .mapped   (mapped),
        .pte      (cached_pte),
        .page_off (vaddr[PAGE_W-1:0]),
        .is_write (req_write),
        .cause    (cause)
    );

    // Response register: address or fault, zeroed while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= (cause != FLT_NONE);
            rsp_cause <= cause;
            rsp_paddr <= (cause != FLT_NONE) ? '0
                                             : {cached_pte.frame, vaddr[PAGE_W-1:0]};
        end
    end
endmodule

// File: rtl/spx_checker.sv
// Cycle-by-cycle properties of the translator handshake and response.
module spx_checker
    import spx_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_ext,
    input logic             seg_wr_en,
    input logic             req_valid,
    input logic [SEL_W-1:0] req_seg,
    input logic [OFF_W-1:0] req_off,
    input logic             req_busy,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause
);
    assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && !seg_wr_en) |=> !(req_busy && $stable(req_seg)
                                       && $stable(req_off) && $stable(mode_ext)));

    assert_busy_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |=> !rsp_valid);

    assert_busy_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |-> req_valid);

    assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    assert_rsp_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_cause == 2'd0));
endmodule

bind seg_page_xlate spx_checker #(.SEL_W(SEL_W)) u_spx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ext  (mode_ext),
    .seg_wr_en (seg_wr_en),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .req_off   (req_off),
    .req_busy  (req_busy),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/tb_seg_page_xlate.sv
`timescale 1ns/1ps
module tb_seg_page_xlate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_ext;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        tbl_wr_en;
    logic [5:0]  tbl_wr_idx;
    logic [31:0] tbl_wr_data;
    logic        req_valid;
    logic [1:0]  req_seg;
    logic [15:0] req_off;
    logic        req_write;
    logic        req_busy;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    seg_page_xlate dut (.*);

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pte(input logic [11:0] fr, input logic [11:0] lim,
                                        input logic [7:0] at);
        return {fr, lim, at};
    endfunction

    task automatic tbl_put(input logic [5:0] idx, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic seg_put(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    // One access: counts busy cycles, then samples the registered response.
    task automatic access(input logic m, input logic [1:0] s, input logic [15:0] o,
                          input logic w, output int nbusy, output logic [23:0] pa,
                          output logic [1:0] cs, output logic flt);
        @(negedge clk);
        mode_ext = m; req_valid = 1'b1; req_seg = s; req_off = o; req_write = w;
        #1;
        nbusy = 0;
        while (req_busy && nbusy < 8) begin
            nbusy++;
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!rsp_valid) begin
            pa = 24'hxxxxxx; cs = 2'bxx; flt = 1'bx;
        end else begin
            pa = rsp_paddr; cs = rsp_cause; flt = rsp_fault;
        end
    endtask

    task automatic t_reset;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        chk("R12 rsp_valid after reset", rsp_valid, 0);
        chk("R12 busy after reset", req_busy, 0);
        tbl_put(0, pte(12'hABC, 12'hFFF, 8'h03));
        seg_put(0, 16'h0012);
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        chk("R12 first access misses", n, 1);
        chk("R3 legacy paddr", pa, 24'hABC465);
    endtask

    task automatic t_legacy_hit_alias;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        chk("R8 hit no busy", n, 0);
        chk("R8 hit paddr", pa, 24'hABC465);
        seg_put(1, 16'h0011);
        access(0, 1, 16'h0355, 0, n, pa, cs, f);
        chk("R1 alias paddr", pa, 24'hABC465);
        seg_put(2, 16'hFFFF);
        access(0, 2, 16'h0010, 0, n, pa, cs, f);
        chk("R1 legacy wrap to page 0", pa, 24'hABC000);
    endtask

    task automatic t_extended;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        tbl_put(1, pte(12'h111, 12'hFFF, 8'h03));
        tbl_put(3, pte(12'h333, 12'hFFF, 8'h03));
        seg_put(3, 16'h0020);
        access(0, 3, 16'h1000, 0, n, pa, cs, f);
        chk("R1 legacy seg*16 page 1", pa, 24'h111200);
        access(1, 3, 16'h1000, 0, n, pa, cs, f);
        chk("R2 extended seg*256 page 3", pa, 24'h333000);
        chk("R2 mode switch misses", n, 1);
        seg_put(3, 16'hFFFF);
        access(1, 3, 16'h0100, 0, n, pa, cs, f);
        chk("R2 extended wraps to page 0", pa, 24'hABC000);
    endtask

    task automatic t_unmapped;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        seg_put(2, 16'h1000);
        access(1, 2, 16'h0000, 0, n, pa, cs, f);
        chk("R11 unmapped no busy", n, 0);
        chk("R11 unmapped cause", cs, 1);
        chk("R7 fault address zero", pa, 0);
        chk("R7 fault flag", f, 1);
    endtask

    task automatic t_absent;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        tbl_put(2, pte(12'h222, 12'hFFF, 8'h00));
        seg_put(0, 16'h0200);
        access(0, 0, 16'h0010, 0, n, pa, cs, f);
        chk("R4 not present cause", cs, 1);
    endtask

    task automatic t_length;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        tbl_put(4, pte(12'h444, 12'h0FF, 8'h03));
        seg_put(1, 16'h0400);
        access(0, 1, 16'h00FF, 0, n, pa, cs, f);
        chk("R5 offset equal length ok", pa, 24'h4440FF);
        chk("R5 offset equal length cause", cs, 0);
        access(0, 1, 16'h0100, 0, n, pa, cs, f);
        chk("R5 offset over length cause", cs, 2);
    endtask

    task automatic t_wprot;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        tbl_put(5, pte(12'h555, 12'hFFF, 8'h01));
        seg_put(2, 16'h0500);
        access(0, 2, 16'h0020, 0, n, pa, cs, f);
        chk("R6 read of read-only ok", pa, 24'h555020);
        access(0, 2, 16'h0020, 1, n, pa, cs, f);
        chk("R6 write to read-only cause", cs, 3);
        chk("R6 write fault flag", f, 1);
    endtask

    task automatic t_priority;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        tbl_put(6, pte(12'h666, 12'h000, 8'h00));
        tbl_put(7, pte(12'h777, 12'h010, 8'h01));
        seg_put(3, 16'h0600);
        access(0, 3, 16'h0005, 1, n, pa, cs, f);
        chk("R7 absent before length", cs, 1);
        seg_put(3, 16'h0700);
        access(0, 3, 16'h0020, 1, n, pa, cs, f);
        chk("R7 length before write", cs, 2);
    endtask

    task automatic t_stale_and_inval;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        seg_put(0, 16'h0012);
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        tbl_put(0, pte(12'hDDD, 12'hFFF, 8'h03));
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        chk("R9 cached entry used", pa, 24'hABC465);
        chk("R9 no table read", n, 0);
        seg_put(0, 16'h0012);
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        chk("R10 miss after segment write", n, 1);
        chk("R10 new table contents", pa, 24'hDDD465);
    endtask

    task automatic t_independent;
        int n; logic [23:0] pa; logic [1:0] cs; logic f;
        seg_put(1, 16'h0100);
        access(0, 1, 16'h0000, 0, n, pa, cs, f);
        chk("R13 other segment refilled", pa, 24'h111000);
        access(0, 0, 16'h0345, 0, n, pa, cs, f);
        chk("R13 segment 0 still hits", n, 0);
        chk("R13 segment 0 paddr", pa, 24'hDDD465);
    endtask

    initial begin
        rst_n = 1'b0; mode_ext = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0;
        seg_wr_data = '0; tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
        req_valid = 1'b0; req_seg = '0; req_off = '0; req_write = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset;
        t_legacy_hit_alias;
        t_extended;
        t_unmapped;
        t_absent;
        t_length;
        t_wprot;
        t_priority;
        t_stale_and_inval;
        t_independent;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule